// File: doc/BRIEF.md
# Serial Port Register Block with Transmit/Receive Status Flags

This block is the software-facing side of an asynchronous serial port. A 32-bit read/write bus with one access per cycle reaches seven word registers: a status word, a data port, a bit-period divisor, and four control words. Writing the data port places a byte in a holding register. When the line is free, the byte moves into a shifter that drives a standard frame on the serial output: one start bit, eight data bits, one stop bit, no parity. Received bytes arrive already assembled, as a one-cycle valid strobe with a byte, and are read back through the same data port.

Three status flags follow an exact access discipline. The holding-empty flag (bit 7) drops on every data write. The line-idle-complete flag (bit 6) drops only when a status read has come first and a data write comes later. The byte-received flag (bit 5) drops when software reads the data port. A single level interrupt combines the three flags with three enable bits.

Top module: `serport_top`

## Requirements
- R1: After reset the status word reads 0x000000C0 (bits 7 and 6 set, bit 5 clear), the interrupt is low and the serial output is high.
- R2: Word offsets: status 0x00, data 0x04, divisor 0x08, control-1 0x0C, control-2 0x10, control-3 0x14, guard/prescale 0x18. The control words read back the full written 32-bit value. The divisor reads back its low 16 bits. Any other offset reads 0.
- R3: Every write to the data offset clears status bit 7 in the following cycle.
- R4: Status bit 6 is cleared by a data write only when a status read has happened since the last data write. A data write with no such read leaves bit 6 set. Each data write uses up the pending status read.
- R5: A status write clears bit 7, 6 or 5 when 0 is written to that bit and leaves it unchanged when 1 is written. Bits 31..8 and 4..0 of the status word always read 0.
- R6: A receive strobe sets status bit 5 and stores the byte, which a data read returns in bits 7..0. A data read clears bit 5, except in a cycle that also carries a receive strobe, where the strobe wins.
- R7: Status bit 7 sets again in the cycle the pending byte moves into the shifter, one cycle after the shifter is free. Status bit 6 sets at the end of a stop bit if bit 7 is then set and no data write occurs in that cycle.
- R8: The serial output is high when idle. A frame is a low start bit, eight data bits LSB first, and a high stop bit. Each bit lasts the divisor's value in cycles, a divisor of 0 acting as 1. The divisor is captured when the frame starts.
- R9: The interrupt equals (bit7 AND ctl1[7]) OR (bit6 AND ctl1[6]) OR (bit5 AND ctl1[5]), with no added delay beyond the flag registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle, 0 when not reading |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | 8 | Received byte |
| tx_line | output | 1 | Serial output |
| irq | output | 1 | Level interrupt |

## Verification
The flags are plain registers, so a wrong flag shows on the very next status read. Through an enabled interrupt it shows in the same cycle. A stale or missing status-read record hides until the next data write, and then appears as bit 6 staying set or clearing one access too early. The reference model therefore runs data writes both with and without a preceding read. A wrong load or period count shifts the serial output by at least one cycle within the first bit time, and the output is compared every clock.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_BAUD  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CTL1  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTL2  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CTL3  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_GUARD = 5'h18;

  localparam int BIT_TXE  = 7;
  localparam int BIT_TC   = 6;
  localparam int BIT_RXNE = 5;

  typedef struct packed {
    logic txe;
    logic tc;
    logic rxne;
  } flags_t;

  typedef struct packed {
    logic rd_any;
    logic stat_rd;
    logic stat_wr;
    logic data_rd;
    logic data_wr;
    logic baud_wr;
    logic ctl1_wr;
    logic ctl2_wr;
    logic ctl3_wr;
    logic guard_wr;
  } strobes_t;
endpackage

// File: rtl/serport_decode.sv
module serport_decode
  import serport_pkg::*;
(
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          strb
);
  logic rd, wt;

  always_comb begin
    rd = sel & ~wr;
    wt = sel & wr;
    strb          = '0;
    strb.rd_any   = rd;
    strb.stat_rd  = rd & (addr == OFS_STAT);
    strb.data_rd  = rd & (addr == OFS_DATA);
    strb.stat_wr  = wt & (addr == OFS_STAT);
    strb.data_wr  = wt & (addr == OFS_DATA);
    strb.baud_wr  = wt & (addr == OFS_BAUD);
    strb.ctl1_wr  = wt & (addr == OFS_CTL1);
    strb.ctl2_wr  = wt & (addr == OFS_CTL2);
    strb.ctl3_wr  = wt & (addr == OFS_CTL3);
    strb.guard_wr = wt & (addr == OFS_GUARD);
  end
endmodule

// File: rtl/serport_flags.sv
module serport_flags
  import serport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_rd,
  input  logic       stat_wr,
  input  logic       data_rd,
  input  logic       data_wr,
  input  logic [2:0] stat_wbits,  // {bit7, bit6, bit5} of the write data
  input  logic       load,
  input  logic       stop_end,
  input  logic       rx_valid,
  output flags_t     flg,
  output logic       armed
);
  flags_t flg_q, flg_d;
  logic   arm_q, arm_d;
  logic   en;

  always_comb begin
    flg_d = flg_q;
    arm_d = arm_q;

    // holding-empty
    if (data_wr)                      flg_d.txe = 1'b0;
    else if (stat_wr && !stat_wbits[2]) flg_d.txe = 1'b0;
    else if (load)                    flg_d.txe = 1'b1;

    // frame complete
    if (stat_wr && !stat_wbits[1])    flg_d.tc = 1'b0;
    else if (data_wr && arm_q)        flg_d.tc = 1'b0;
    else if (stop_end && flg_q.txe && !data_wr) flg_d.tc = 1'b1;

    // byte received
    if (rx_valid)                     flg_d.rxne = 1'b1;
    else if (data_rd)                 flg_d.rxne = 1'b0;
    else if (stat_wr && !stat_wbits[0]) flg_d.rxne = 1'b0;

    // status-read record
    if (stat_rd)                      arm_d = 1'b1;
    else if (data_wr)                 arm_d = 1'b0;
  end

  assign en = stat_rd | stat_wr | data_rd | data_wr | load | stop_end | rx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '{txe: 1'b1, tc: 1'b1, rxne: 1'b0};
      arm_q <= 1'b0;
    end else if (en) begin
      flg_q <= flg_d;
      arm_q <= arm_d;
    end
  end

  assign flg   = flg_q;
  assign armed = arm_q;
endmodule

// File: rtl/serport_txshift.sv
module serport_txshift #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [DIV_W-1:0]  div,
  output logic              busy,
  output logic              stop_end,
  output logic              line
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               busy_q, busy_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   bit_q, bit_d;
  logic [DIV_W-1:0]   tick_q, tick_d;
  logic [DIV_W-1:0]   per_q, per_d;
  logic [DIV_W-1:0]   per_new;
  logic               period_end, last_bit, en;

  assign per_new    = (div == '0) ? DIV_W'(1) : div;
  assign period_end = busy_q && (tick_q == '0);
  assign last_bit   = (bit_q == LAST);

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    tick_d = tick_q;
    per_d  = per_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      sh_d   = {1'b1, byte_in, 1'b0};
      bit_d  = '0;
      per_d  = per_new;
      tick_d = per_new - DIV_W'(1);
    end else if (period_end) begin
      if (last_bit) begin
        busy_d = 1'b0;
      end else begin
        sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
        bit_d  = bit_q + CNT_W'(1);
        tick_d = per_q - DIV_W'(1);
      end
    end else if (busy_q) begin
      tick_d = tick_q - DIV_W'(1);
    end
  end

  assign en = start | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      bit_q  <= '0;
      tick_q <= '0;
      per_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      tick_q <= tick_d;
      per_q  <= per_d;
    end
  end

  assign busy     = busy_q;
  assign stop_end = period_end && last_bit;
  assign line     = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/serport_regs.sv
module serport_regs
  import serport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  flags_t            flg,
  output logic [DATA_W-1:0] hold_byte,
  output logic [DIV_W-1:0]  div,
  output logic [2:0]        ien,
  output logic [BUS_W-1:0]  rdata
);
  logic [DATA_W-1:0] hold_q, rxb_q;
  logic [DIV_W-1:0]  div_q;
  logic [BUS_W-1:0]  ctl_q [4];
  logic [3:0]        ctl_we;

  assign ctl_we = {strb.guard_wr, strb.ctl3_wr, strb.ctl2_wr, strb.ctl1_wr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hold_q <= '0;
    else if (strb.data_wr)  hold_q <= wdata[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rxb_q <= '0;
    else if (rx_valid)      rxb_q <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_q <= '0;
    else if (strb.baud_wr)  div_q <= wdata[DIV_W-1:0];
  end

  for (genvar i = 0; i < 4; i++) begin : g_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ctl_q[i] <= '0;
      else if (ctl_we[i])   ctl_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (strb.rd_any) begin
      case (addr)
        OFS_STAT: begin
          rdata[BIT_TXE]  = flg.txe;
          rdata[BIT_TC]   = flg.tc;
          rdata[BIT_RXNE] = flg.rxne;
        end
        OFS_DATA:  rdata = BUS_W'(rxb_q);
        OFS_BAUD:  rdata = BUS_W'(div_q);
        OFS_CTL1:  rdata = ctl_q[0];
        OFS_CTL2:  rdata = ctl_q[1];
        OFS_CTL3:  rdata = ctl_q[2];
        OFS_GUARD: rdata = ctl_q[3];
        default:   rdata = '0;
      endcase
    end
  end

  assign hold_byte = hold_q;
  assign div       = div_q;
  assign ien       = {ctl_q[0][BIT_TXE], ctl_q[0][BIT_TC], ctl_q[0][BIT_RXNE]};
endmodule

// File: rtl/serport_top.sv
module serport_top
  import serport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_line,
  output logic              irq
);
  strobes_t          strb;
  flags_t            flg;
  logic              armed;
  logic              tx_busy, stop_end, load;
  logic [DATA_W-1:0] hold_byte;
  logic [DIV_W-1:0]  div;
  logic [2:0]        ien;

  serport_decode u_dec (
    .sel  (bus_sel),
    .wr   (bus_wr),
    .addr (bus_addr),
    .strb (strb)
  );

  assign load = !tx_busy && !flg.txe;

  serport_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_rd    (strb.stat_rd),
    .stat_wr    (strb.stat_wr),
    .data_rd    (strb.data_rd),
    .data_wr    (strb.data_wr),
    .stat_wbits ({bus_wdata[BIT_TXE], bus_wdata[BIT_TC], bus_wdata[BIT_RXNE]}),
    .load       (load),
    .stop_end   (stop_end),
    .rx_valid   (rx_valid),
    .flg        (flg),
    .armed      (armed)
  );

  serport_txshift #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (load),
    .byte_in  (hold_byte),
    .div      (div),
    .busy     (tx_busy),
    .stop_end (stop_end),
    .line     (tx_line)
  );

  serport_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .flg       (flg),
    .hold_byte (hold_byte),
    .div       (div),
    .ien       (ien),
    .rdata     (bus_rdata)
  );

  assign irq = |({flg.txe, flg.tc, flg.rxne} & ien);
endmodule

// File: rtl/serport_checker.sv
module serport_checker
  import serport_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input flags_t           flg,
  input logic             armed,
  input logic             stat_rd,
  input logic             stat_wr,
  input logic             data_wr,
  input logic             tx_busy,
  input logic             tx_line,
  input logic             stop_end,
  input logic             rx_valid,
  input logic [BUS_W-1:0] bus_rdata
);
  a_r3_txe_clear: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !flg.txe);

  a_r4_tc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !armed && flg.tc) |=> flg.tc);

  a_r4_arm_used: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !armed);

  a_r5_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (bus_rdata[BUS_W-1:8] == '0 && bus_rdata[4:0] == '0));

  a_r6_rx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> flg.rxne);

  a_r7_tc_needs_txe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg.tc) |-> flg.txe);

  a_r7_tc_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_end && flg.txe && !data_wr && !stat_wr) |=> flg.tc);

  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);
endmodule

bind serport_top serport_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flg       (flg),
  .armed     (armed),
  .stat_rd   (strb.stat_rd),
  .stat_wr   (strb.stat_wr),
  .data_wr   (strb.data_wr),
  .tx_busy   (tx_busy),
  .tx_line   (tx_line),
  .stop_end  (stop_end),
  .rx_valid  (rx_valid),
  .bus_rdata (bus_rdata)
);

// File: tb/tb_serport_top.sv
module tb_serport_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        tx_line, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serport_top dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_line(tx_line), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit          m_txe, m_tc, m_rxne, m_arm, m_busy;
  int          m_hold, m_div, m_cr1, m_per, m_cnt;
  bit          m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_txe = 1; m_tc = 1; m_rxne = 0; m_arm = 0; m_busy = 0;
      m_hold = 0; m_div = 0; m_cr1 = 0; m_per = 1; m_cnt = 0;
      m_q.delete();
    end else begin
      bit s_rd, s_wr, d_rd, d_wr, stop_end, load;
      bit o_txe;
      s_rd = bus_sel && !bus_wr && bus_addr == 5'h00;
      s_wr = bus_sel &&  bus_wr && bus_addr == 5'h00;
      d_rd = bus_sel && !bus_wr && bus_addr == 5'h04;
      d_wr = bus_sel &&  bus_wr && bus_addr == 5'h04;
      stop_end = m_busy && m_cnt == 0 && m_q.size() == 1;
      load = !m_busy && !m_txe;
      o_txe = m_txe;
      // line model
      if (m_busy) begin
        if (m_cnt == 0) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) m_busy = 0;
          else m_cnt = m_per - 1;
        end else m_cnt--;
      end else if (load) begin
        m_q.push_back(0);
        for (int i = 0; i < 8; i++) m_q.push_back(m_hold[i]);
        m_q.push_back(1);
        m_per = (m_div == 0) ? 1 : m_div;
        m_cnt = m_per - 1;
        m_busy = 1;
      end
      // flags
      if (d_wr) m_txe = 0;
      else if (s_wr && !bus_wdata[7]) m_txe = 0;
      else if (load) m_txe = 1;
      if (s_wr && !bus_wdata[6]) m_tc = 0;
      else if (d_wr && m_arm) m_tc = 0;
      else if (stop_end && o_txe && !d_wr) m_tc = 1;
      if (rx_valid) m_rxne = 1;
      else if (d_rd) m_rxne = 0;
      else if (s_wr && !bus_wdata[5]) m_rxne = 0;
      if (s_rd) m_arm = 1;
      else if (d_wr) m_arm = 0;
      // registers
      if (d_wr) m_hold = bus_wdata[7:0];
      if (bus_sel && bus_wr && bus_addr == 5'h08) m_div = bus_wdata[15:0];
      if (bus_sel && bus_wr && bus_addr == 5'h0C) m_cr1 = bus_wdata;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // every-cycle comparison of the serial output and interrupt
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      bit e_line, e_irq;
      e_line = m_busy ? m_q[0] : 1'b1;
      e_irq = (m_txe & m_cr1[7]) | (m_tc & m_cr1[6]) | (m_rxne & m_cr1[5]);
      check("R8 tx_line", {31'b0, tx_line}, {31'b0, e_line});
      check("R9 irq", {31'b0, irq}, {31'b0, e_irq});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 check(tag, bus_rdata, exp);
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_data = 0;
    repeat (3) @(negedge clk);
    #1 check("R1 irq at reset", {31'b0, irq}, 0);
    check("R1 line at reset", {31'b0, tx_line}, 1);
    @(negedge clk); rst_n = 1;
    rd(5'h00, 32'h0000_00C0, "R1 status reset value");

    // R2 register map
    wr(5'h10, 32'h1234_ABCD); rd(5'h10, 32'h1234_ABCD, "R2 ctl2");
    wr(5'h14, 32'h0000_BEEF); rd(5'h14, 32'h0000_BEEF, "R2 ctl3");
    wr(5'h18, 32'h0000_0055); rd(5'h18, 32'h0000_0055, "R2 guard");
    wr(5'h0C, 32'h0000_1F1F); rd(5'h0C, 32'h0000_1F1F, "R2 ctl1");
    wr(5'h0C, 32'h0);
    wr(5'h08, 32'h0000_0003); rd(5'h08, 32'h0000_0003, "R2 divisor");
    rd(5'h1C, 32'h0, "R2 unmapped offset");

    // R3/R4: data write after status read clears both
    wr(5'h04, 32'h0000_00A5);
    rd(5'h00, 32'h0000_0000, "R3 R4 data write after status read");
    idle(40);
    rd(5'h00, 32'h0000_00C0, "R7 flags after frame");
    wr(5'h04, 32'h0000_003C);  // consumes the pending read
    idle(40);
    wr(5'h04, 32'h0000_005A);  // no status read before it
    rd(5'h00, 32'h0000_0040, "R4 TC kept without prior status read");
    idle(40);

    // R5 status writes
    wr(5'h00, 32'hFFFF_FFA0);
    rd(5'h00, 32'h0000_0080, "R5 zero clears TC only");

    // R6 receive path
    rx(8'h96);
    rd(5'h00, 32'h0000_00A0, "R6 RXNE set");
    rd(5'h04, 32'h0000_0096, "R6 data read");
    rd(5'h00, 32'h0000_0080, "R6 RXNE cleared by data read");
    rx(8'h11);
    wr(5'h00, 32'h0000_00C0);
    rd(5'h00, 32'h0000_0080, "R5 zero clears RXNE, one keeps TC clear");
    rx(8'h11);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 5'h04; rx_valid = 1; rx_data = 8'h22;
    #1 check("R6 read returns old byte", bus_rdata, 32'h11);
    @(posedge clk); #1; bus_sel = 0; rx_valid = 0;
    rd(5'h00, 32'h0000_00A0, "R6 strobe wins over read clear");
    rd(5'h04, 32'h0000_0022, "R6 new byte");

    // R9 interrupt
    wr(5'h0C, 32'h20);
    #1 check("R9 irq rx enabled, empty", {31'b0, irq}, 0);
    rx(8'h33);
    #1 check("R9 irq on RXNE", {31'b0, irq}, 1);
    rd(5'h04, 32'h33, "R6 byte 0x33");
    #1 check("R9 irq dropped by data read", {31'b0, irq}, 0);
    wr(5'h0C, 32'h80);
    #1 check("R9 irq on TXE", {31'b0, irq}, 1);
    wr(5'h0C, 32'h40);
    #1 check("R9 irq TC clear", {31'b0, irq}, 0);
    wr(5'h0C, 32'h0);

    // R8 divisor zero acts as one; back-to-back bytes
    wr(5'h08, 32'h0);
    wr(5'h04, 32'h0000_00C3);
    idle(20);
    rd(5'h00, 32'h0000_00C0, "R7 R8 frame at divisor 0");
    wr(5'h08, 32'h2);
    wr(5'h04, 32'h0000_0081);
    wr(5'h04, 32'h0000_007E);
    idle(60);
    rd(5'h00, 32'h0000_00C0, "R7 two queued frames");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule